// File: doc/BRIEF.md
# Programmable-Polynomial CRC Shift Engine

This block runs a cyclic redundancy check over a stream of data words. The generator polynomial is set at run time. A length field gives the order of the polynomial. A 32-bit tap mask picks which exponent terms feed back. Words come one at a time from an upstream queue, through an "available" flag, a data bus and a one-cycle pop strobe.

While the go input is high and a word is waiting, the engine pops the word into a shift buffer. It then folds the data into the CRC register, most-significant bit first, two bits per clock. If another word is waiting during the final step of the current word, that word is popped in the same cycle, so consecutive words leave no idle gap.

The CRC register is cleared while the module is disabled. A synchronous load port writes a seed value into it. Bit reflection, final inversion and the queue itself belong to the surrounding logic.

Top module: `crc_shift_engine`

## Requirements
- R1: The field `poly_len` holds the polynomial order minus one (15 for a 16-bit CRC, 31 for a 32-bit CRC). Only CRC bits 0..`poly_len` are used, and every `crc_out` bit above `poly_len` always reads zero.
- R2: Tap mask bit i set adds an XOR of the feedback into CRC bit i; a cleared bit removes it. The x^0 term is always applied, so mask bit 0 has no effect. Mask bits above `poly_len` have no effect.
- R3: A word is popped (`word_pop` high for one cycle) only when `enable`, `go` and `word_avail` are all high. With `go` low, no word is taken and `busy` stays low.
- R4: Each `word_pop` moves exactly one queue word into the shift buffer. The number of pops equals the number of words processed.
- R5: The engine processes two data bits per clock. `busy` rises in the cycle after a pop, and a word of width W keeps it high for ceil(W/2) cycles. A 32-bit word takes 16 cycles.
- R6: The data width is `data_width_m1`+1. Bits enter the CRC from bit W-1 down to bit 0, and `word_data` bits at or above W are ignored.
- R7: For an odd width, the last cycle of a word processes a single bit.
- R8: While words remain available and `go` stays high, processing continues back to back. N words of width W keep `busy` high for N*ceil(W/2) consecutive cycles, and `crc_out` holds the final CRC once `busy` falls.
- R9: With `enable` low, the CRC register and the shift state clear in the next cycle (`crc_out` = 0, `busy` = 0), any word in progress is abandoned, and no pops occur.
- R10: With `enable` high, `seed_load` writes `seed_value` masked to bits 0..`poly_len` into the CRC register at the next clock edge.
- R11: After reset, `crc_out` is zero, `busy` is low and `word_pop` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Module enable; low clears the CRC and the shift state |
| go | input | 1 | Permits popping and processing of words |
| poly_len | input | 5 | Polynomial order minus one |
| tap_mask | input | 32 | Feedback tap per exponent position |
| data_width_m1 | input | 5 | Data word width minus one |
| word_avail | input | 1 | Upstream queue holds at least one word |
| word_data | input | 32 | Word at the head of the upstream queue |
| word_pop | output | 1 | Takes the head word this cycle |
| seed_load | input | 1 | Loads the seed into the CRC register |
| seed_value | input | 32 | Seed value |
| crc_out | output | 32 | Running CRC register |
| busy | output | 1 | A buffered word is being shifted |

## Verification
The bench builds the block with its default parameters: a 32-bit CRC register and two bits per clock. This allows every polynomial order from 1 to 32 and every data width up to 32. Two known check values are confirmed: a 16-bit CCITT run and a 32-bit run, both over the ASCII digits one to nine. Further runs use the 5-bit and 1-bit odd widths, a 4-bit polynomial with an oversize seed, and garbage above the data width. Go held off, disabling mid-word and back-to-back word timing are checked with a cycle-exact `busy` count.

// File: rtl/crc_eng_pkg.sv
// Package: shared sizes and helpers for the CRC shift engine.
// Assumes the CRC register width is a power of two, so that the
// order field holds exactly width-1.
package crc_eng_pkg;

    localparam int CRC_W     = 32;
    localparam int LEN_W     = $clog2(CRC_W);
    localparam int CNT_W     = $clog2(CRC_W + 1);
    localparam int DEF_STEPS = 2;

    typedef logic [CRC_W-1:0] crc_word_t;

    // Mask of CRC bits 0..len, i.e. the bits that belong to the polynomial.
    function automatic crc_word_t len_mask(input logic [LEN_W-1:0] len);
        crc_word_t m;
        for (int i = 0; i < CRC_W; i++) begin
            m[i] = (i <= int'(len));
        end
        return m;
    endfunction

endpackage

// File: rtl/crc_bit_step.sv
// Module: crc_bit_step
// Folds one data bit into the CRC state (MSB-first division step).
// Assumes taps_eff already carries the x^0 term and is masked to the order.
module crc_bit_step
    import crc_eng_pkg::*;
(
    input  crc_word_t        crc_in,
    input  logic             din,
    input  logic             en,
    input  crc_word_t        taps_eff,
    input  crc_word_t        len_msk,
    input  logic [LEN_W-1:0] top_idx,
    output crc_word_t        crc_nxt
);

    logic      fb;
    crc_word_t shifted;

    // One division step: shift, then XOR the taps when feedback is set.
    always_comb begin
        fb      = crc_in[top_idx] ^ din;
        shifted = (crc_in << 1) & len_msk;
        if (!en) begin
            crc_nxt = crc_in;
        end else if (fb) begin
            crc_nxt = shifted ^ taps_eff;
        end else begin
            crc_nxt = shifted;
        end
    end

endmodule

// File: rtl/crc_multi_step.sv
// Module: crc_multi_step
// Chains STEPS single-bit steps so that STEPS bits are folded per clock.
// Assumes din[0] is the first (most significant) bit of the group,
// and that a disabled stage passes its input through unchanged.
module crc_multi_step
    import crc_eng_pkg::*;
#(
    parameter int STEPS = DEF_STEPS
) (
    input  crc_word_t        crc_in,
    input  logic [STEPS-1:0] din,
    input  logic [STEPS-1:0] en,
    input  crc_word_t        taps_eff,
    input  crc_word_t        len_msk,
    input  logic [LEN_W-1:0] top_idx,
    output crc_word_t        crc_nxt
);

    crc_word_t stage [STEPS+1];

    assign stage[0] = crc_in;

    for (genvar k = 0; k < STEPS; k++) begin : g_step
        crc_bit_step u_step (
            .crc_in   (stage[k]),
            .din      (din[k]),
            .en       (en[k]),
            .taps_eff (taps_eff),
            .len_msk  (len_msk),
            .top_idx  (top_idx),
            .crc_nxt  (stage[k+1])
        );
    end

    assign crc_nxt = stage[STEPS];

endmodule

// File: rtl/crc_word_sequencer.sv
// Module: crc_word_sequencer
// Pops words from the upstream queue, left-aligns them in a shift buffer
// and hands out up to STEPS bits per clock, MSB first.
// Assumes word_data is stable while word_avail is high and not popped.
module crc_word_sequencer
    import crc_eng_pkg::*;
#(
    parameter int STEPS = DEF_STEPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             go,
    input  logic             word_avail,
    input  crc_word_t        word_data,
    input  logic [LEN_W-1:0] width_m1,
    output logic             word_pop,
    output logic             busy,
    output logic [STEPS-1:0] step_bits,
    output logic [STEPS-1:0] step_en
);

    localparam logic [CNT_W-1:0] STEP_CNT = CNT_W'(STEPS);
    localparam logic [LEN_W-1:0] TOP_BIT  = LEN_W'(CRC_W - 1);

    crc_word_t        shift_buf;
    logic [CNT_W-1:0] bits_left;

    assign busy     = (bits_left != '0);
    // Take a new word when idle or on the final step of the current one.
    assign word_pop = enable && go && word_avail && (bits_left <= STEP_CNT);

    for (genvar k = 0; k < STEPS; k++) begin : g_tap
        assign step_bits[k] = shift_buf[CRC_W-1-k];
        assign step_en[k]   = (bits_left > CNT_W'(k));
    end

    // Buffer and remaining-bit count: load on pop, shift while busy.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            shift_buf <= '0;
            bits_left <= '0;
        end else if (word_pop) begin
            shift_buf <= word_data << (TOP_BIT - width_m1);
            bits_left <= CNT_W'(width_m1) + CNT_W'(1);
        end else if (busy) begin
            shift_buf <= shift_buf << STEPS;
            bits_left <= (bits_left > STEP_CNT) ? bits_left - STEP_CNT : '0;
        end
    end

endmodule

// File: rtl/crc_shift_engine.sv
// Module: crc_shift_engine (top)
// Run-time programmable CRC engine: the order comes from poly_len, the
// feedback taps from tap_mask, and data is folded STEPS bits per clock.
// Assumes an upstream queue with avail/data/pop semantics.
module crc_shift_engine
    import crc_eng_pkg::*;
#(
    parameter int BITS_PER_CLK = DEF_STEPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              go,
    input  logic [LEN_W-1:0]  poly_len,
    input  logic [CRC_W-1:0]  tap_mask,
    input  logic [LEN_W-1:0]  data_width_m1,
    input  logic              word_avail,
    input  logic [CRC_W-1:0]  word_data,
    output logic              word_pop,
    input  logic              seed_load,
    input  logic [CRC_W-1:0]  seed_value,
    output logic [CRC_W-1:0]  crc_out,
    output logic              busy
);

    crc_word_t               crc_q;
    crc_word_t               crc_stepped;
    crc_word_t               len_msk;
    crc_word_t               taps_eff;
    logic [BITS_PER_CLK-1:0] step_bits;
    logic [BITS_PER_CLK-1:0] step_en;

    // Polynomial decode: order mask and taps with x^0 always applied.
    always_comb begin
        len_msk  = len_mask(poly_len);
        taps_eff = (tap_mask | crc_word_t'(1)) & len_msk;
    end

    crc_word_sequencer #(.STEPS(BITS_PER_CLK)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .go         (go),
        .word_avail (word_avail),
        .word_data  (word_data),
        .width_m1   (data_width_m1),
        .word_pop   (word_pop),
        .busy       (busy),
        .step_bits  (step_bits),
        .step_en    (step_en)
    );

    crc_multi_step #(.STEPS(BITS_PER_CLK)) u_steps (
        .crc_in   (crc_q),
        .din      (step_bits),
        .en       (step_en),
        .taps_eff (taps_eff),
        .len_msk  (len_msk),
        .top_idx  (poly_len),
        .crc_nxt  (crc_stepped)
    );

    // CRC register: clear when disabled, seed load wins over shifting.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            crc_q <= '0;
        end else if (seed_load) begin
            crc_q <= seed_value & len_msk;
        end else begin
            crc_q <= crc_stepped & len_msk;
        end
    end

    assign crc_out = crc_q;

endmodule

// File: rtl/crc_shift_engine_chk.sv
// Module: crc_shift_engine_chk
// Protocol and state checks for crc_shift_engine, attached by bind.
// Assumes port names identical to the top module.
module crc_shift_engine_chk
    import crc_eng_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              go,
    input logic [LEN_W-1:0]  poly_len,
    input logic [CRC_W-1:0]  tap_mask,
    input logic [LEN_W-1:0]  data_width_m1,
    input logic              word_avail,
    input logic [CRC_W-1:0]  word_data,
    input logic              word_pop,
    input logic              seed_load,
    input logic [CRC_W-1:0]  seed_value,
    input logic [CRC_W-1:0]  crc_out,
    input logic              busy
);

    // R1: bits above the order stay zero.
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_out & ~len_mask($past(poly_len))) == '0);

    // R3: a pop needs enable, go and an available word.
    a_r3_pop_gated: assert property (@(posedge clk) disable iff (!rst_n)
        word_pop |-> (enable && go && word_avail));

    // R5: a pop starts shifting in the next cycle.
    a_r5_busy_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        word_pop |=> busy);

    // R9: disabling clears the CRC and the shift state.
    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (crc_out == '0 && !busy));

    // R10: the seed is loaded, masked to the order.
    a_r10_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && seed_load) |=>
            crc_out == ($past(seed_value) & len_mask($past(poly_len))));

endmodule

bind crc_shift_engine crc_shift_engine_chk u_chk (.*);

// File: tb/crc_shift_engine_bench.sv
// Scoreboard bench: the driver queues expected results per job, the
// monitor compares them when busy falls.
module crc_shift_engine_bench;

    typedef struct {
        logic [31:0] crc;
        int          cycles;
        string       req;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        enable = 0;
    logic        go = 0;
    logic [4:0]  poly_len = 0;
    logic [31:0] tap_mask = 0;
    logic [4:0]  data_width_m1 = 0;
    logic        word_avail;
    logic [31:0] word_data;
    logic        word_pop;
    logic        seed_load = 0;
    logic [31:0] seed_value = 0;
    logic [31:0] crc_out;
    logic        busy;

    logic [31:0] fifo_mem [64];
    int          rd_ptr = 0;
    int          wr_cnt = 0;
    logic        flush = 0;
    int          pop_count = 0;
    logic [31:0] job_words [64];

    exp_t exp_q [$];
    int   checks = 0;
    int   failures = 0;
    int   run_cycles = 0;
    logic prev_busy = 0;

    always #2 clk = ~clk;

    assign word_avail = (rd_ptr != wr_cnt);
    assign word_data  = fifo_mem[rd_ptr % 64];

    crc_shift_engine u_crc_shift_engine (
        .clk (clk), .rst_n (rst_n), .enable (enable), .go (go),
        .poly_len (poly_len), .tap_mask (tap_mask),
        .data_width_m1 (data_width_m1), .word_avail (word_avail),
        .word_data (word_data), .word_pop (word_pop),
        .seed_load (seed_load), .seed_value (seed_value),
        .crc_out (crc_out), .busy (busy)
    );

    // Upstream queue model: advance the read pointer on each pop.
    always @(posedge clk) begin
        if (flush) rd_ptr <= wr_cnt;
        else if (word_pop) begin
            rd_ptr    <= rd_ptr + 1;
            pop_count <= pop_count + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: count busy cycles, compare the queued result when busy falls.
    always @(negedge clk) begin
        if (busy) run_cycles++;
        if (prev_busy && !busy) begin
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check({e.req, " crc"}, crc_out, e.crc);
                check({e.req, " cycles"}, run_cycles, e.cycles);
            end
            run_cycles = 0;
        end
        prev_busy = busy;
    end

    function automatic logic [31:0] lmask(input int len);
        return (len >= 31) ? 32'hFFFF_FFFF : ((32'd1 << (len + 1)) - 1);
    endfunction

    // Reference: MSB-first polynomial division over job_words[0..n-1].
    function automatic logic [31:0] model(input logic [31:0] seed, input int len,
                                          input logic [31:0] mask, input int w, input int n);
        logic [31:0] c = seed & lmask(len);
        logic [31:0] t = (mask | 32'd1) & lmask(len);
        for (int j = 0; j < n; j++) begin
            for (int i = w - 1; i >= 0; i--) begin
                logic fb = c[len] ^ job_words[j][i];
                c = (c << 1) & lmask(len);
                if (fb) c = c ^ t;
            end
        end
        return c;
    endfunction

    task automatic configure(input int len, input logic [31:0] mask,
                             input logic [31:0] seed, input int wm1);
        @(negedge clk);
        enable = 1; poly_len = 5'(len); tap_mask = mask; data_width_m1 = 5'(wm1);
        seed_value = seed; seed_load = 1;
        @(negedge clk);
        seed_load = 0;
    endtask

    task automatic push_words(input int n);
        for (int j = 0; j < n; j++) begin
            fifo_mem[wr_cnt % 64] = job_words[j];
            wr_cnt++;
        end
    endtask

    // Driver: queue expectation, feed words, run until the monitor consumes it.
    task automatic run_job(input string req, input logic [31:0] exp_crc, input int n, input int w);
        exp_t e;
        int   pops0 = pop_count;
        e.crc = exp_crc; e.cycles = n * ((w + 1) / 2); e.req = req;
        exp_q.push_back(e);
        push_words(n);
        @(negedge clk);
        go = 1;
        while (exp_q.size() > 0) @(negedge clk);
        go = 0;
        check({req, " R4 pop count"}, pop_count - pops0, n);
        check({req, " R1 upper bits"}, crc_out & ~lmask(int'(poly_len)), 32'd0);
    endtask

    initial begin
        logic [31:0] tmp;
        int          pops_before;
        repeat (3) @(negedge clk);
        // R11: reset state.
        check("R11 crc", crc_out, 0);
        check("R11 busy", busy, 0);
        check("R11 pop", word_pop, 0);
        rst_n = 1;

        // R6 R8: 16-bit CCITT over "123456789", garbage above bit 7.
        for (int j = 0; j < 9; j++) job_words[j] = 32'hA5A5_A500 | 32'(8'h31 + j);
        configure(15, 32'h1021, 32'hFFFF, 7);
        run_job("R6 R8 crc16", 32'h29B1, 9, 8);
        // R2: mask bit 0 has no effect; bits above the order likewise.
        configure(15, 32'hFFFF_1020, 32'hFFFF, 7);
        run_job("R2 crc16 taps", 32'h29B1, 9, 8);
        // R8: 32-bit polynomial, same data.
        configure(31, 32'h04C1_1DB7, 32'hFFFF_FFFF, 7);
        run_job("R8 crc32", 32'h0376_E6E7, 9, 8);
        // R5: one 32-bit word takes 16 cycles.
        job_words[0] = 32'hDEAD_BEEF;
        configure(31, 32'h04C1_1DB7, 32'hFFFF_FFFF, 31);
        run_job("R5 wide word", model(32'hFFFF_FFFF, 31, 32'h04C1_1DB7, 32, 1), 1, 32);
        // R7: odd width 5 with a 5th-order polynomial.
        job_words[0] = 32'hFFFF_FF1B; job_words[1] = 32'h0000_0107; job_words[2] = 32'h8000_0012;
        configure(4, 32'h05, 32'h0A, 4);
        run_job("R7 width5", model(32'h0A, 4, 32'h05, 5, 3), 3, 5);
        // R7: width 1, single bit per word.
        job_words[0] = 1; job_words[1] = 0; job_words[2] = 32'hFFFF_FFFF; job_words[3] = 32'hFFFF_FFFE;
        configure(7, 32'h07, 32'h00, 0);
        run_job("R7 width1", model(32'h00, 7, 32'h07, 1, 4), 4, 1);
        // R10 R1: oversize seed masked to a 4-bit polynomial.
        configure(3, 32'h03, 32'hFFFF_FFFF, 7);
        check("R10 seed masked", crc_out, 32'h0000_000F);
        configure(31, 32'h03, 32'h1234_5678, 7);
        check("R10 seed full", crc_out, 32'h1234_5678);

        // R3: words waiting but go low.
        job_words[0] = 32'h0123_4567; job_words[1] = 32'h89AB_CDEF;
        configure(31, 32'h04C1_1DB7, 32'hFFFF_FFFF, 31);
        pops_before = pop_count;
        push_words(2);
        repeat (6) @(negedge clk);
        check("R3 no pop with go low", pop_count - pops_before, 0);
        check("R3 busy low with go low", busy, 0);
        check("R3 crc held", crc_out, 32'hFFFF_FFFF);
        wr_cnt -= 2;
        run_job("R3 R8 after go", model(32'hFFFF_FFFF, 31, 32'h04C1_1DB7, 32, 2), 2, 32);

        // R9: disable in the middle of a word.
        configure(31, 32'h04C1_1DB7, 32'hFFFF_FFFF, 31);
        push_words(2);
        @(negedge clk); go = 1;
        repeat (4) @(negedge clk);
        enable = 0;
        @(negedge clk);
        check("R9 crc cleared", crc_out, 0);
        check("R9 busy cleared", busy, 0);
        pops_before = pop_count;
        repeat (3) @(negedge clk);
        check("R9 no pops while disabled", pop_count - pops_before, 0);
        tmp = crc_out;
        check("R9 crc stays zero", tmp, 0);
        go = 0; flush = 1;
        @(negedge clk); flush = 0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule